// File: doc/BRIEF.md
# Branch Direction Predictor with Next-PC Selection

This block sits in an instruction fetch stage and chooses the address to fetch after the current one. It keeps a table of 2-bit saturating counters, one per slot. A slice of the fetch address selects the slot. The fetched word is decoded only far enough to tell whether it is a conditional branch. For a branch whose counter leans taken, the next address is the branch target, formed by a PC-relative adder. Every other case falls through to the sequential address.

A separate resolution port trains the table. When a branch resolves later in the pipeline, its address and actual direction are presented for one cycle. The slot that address maps to then moves one step toward the observed outcome. Prediction is combinational from the stored counters. Training takes effect at the next clock edge.

Top module: `bht_predictor`

## Requirements
- R1: A synchronous active-low reset puts every counter at 2'b01 (weakly not-taken). Directly after reset, a branch is predicted not-taken, and a single taken training step makes it predicted taken.
- R2: A resolution with outcome taken raises the addressed counter by one, stopping at 2'b11.
- R3: A resolution with outcome not-taken lowers the addressed counter by one, stopping at 2'b00.
- R4: A branch is predicted taken exactly when its counter's upper bit is 1, that is, when the counter is 2'b10 or 2'b11.
- R5: The slot is selected by address bits [IDX_W+1:2]. Two addresses that agree in those bits share one counter, and training one slot leaves the other slots unchanged.
- R6: An instruction is a conditional branch only when bits [31:26] equal the parameter BR_OPC (default 6'b000100). Any other value, including one that differs in a single bit, is not a branch.
- R7: The branch target is the fetch address plus the 16-bit field in bits [15:0], sign-extended and multiplied by 4. A negative offset therefore targets a lower address.
- R8: When the fetched word is not a branch, next_pc is fetch_pc + 4 and pred_taken is 0, whatever the counter holds.
- R9: When a prediction and a training step address the same slot in one cycle, the prediction uses the value held before the training step.
- R10: While upd_valid is 0, no counter changes, whatever upd_pc and upd_taken carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fetch_pc | input | ADDR_W | Address of the instruction being fetched |
| fetch_instr | input | 32 | Instruction word at fetch_pc |
| next_pc | output | ADDR_W | Address to fetch next |
| pred_taken | output | 1 | High when a branch is predicted taken |
| upd_valid | input | 1 | Resolution strobe |
| upd_pc | input | ADDR_W | Address of the resolved branch |
| upd_taken | input | 1 | Actual direction of the resolved branch |

## Verification
A single slot is walked up through all four counter values and down again, with extra steps at each end. The predicted direction after every step shows both that the count moves and that it saturates rather than wrapping. Two addresses that differ only above the index bits are trained through each other, while a third address in another slot is watched so that sharing can be told apart from cross-talk. Non-branch words, an opcode one bit away from the branch code and a negative offset are fetched from a trained-taken slot. These separate the decode gate from the target adder. Same-cycle fetch and training to one slot, and training data presented with the strobe low, show how read ordering and enable behave.

// File: rtl/bht_pkg.sv
package bht_pkg;
  localparam int INSTR_W = 32;

  typedef enum logic [1:0] {
    CTR_SNT = 2'b00,
    CTR_WNT = 2'b01,
    CTR_WT  = 2'b10,
    CTR_ST  = 2'b11
  } ctr_e;

  // one saturating step toward the observed outcome
  function automatic logic [1:0] ctr_step(input logic [1:0] cur, input logic taken);
    if (taken) return (cur == CTR_ST) ? cur : cur + 2'd1;
    else       return (cur == CTR_SNT) ? cur : cur - 2'd1;
  endfunction

  function automatic logic ctr_dir(input logic [1:0] cur);
    return cur[1];
  endfunction
endpackage

// File: rtl/bht_decode.sv
module bht_decode
  import bht_pkg::*;
#(
  parameter int          ADDR_W = 32,
  parameter logic [5:0]  BR_OPC = 6'b000100
) (
  input  logic [ADDR_W-1:0]  pc,
  input  logic [INSTR_W-1:0] instr,
  output logic               is_branch,
  output logic [ADDR_W-1:0]  br_target,
  output logic [ADDR_W-1:0]  seq_pc
);
  localparam int OFF_W = 16;

  function automatic logic [ADDR_W-1:0] rel_target(input logic [ADDR_W-1:0] base,
                                                   input logic [OFF_W-1:0] off);
    logic [ADDR_W-1:0] disp;
    disp = {{(ADDR_W-OFF_W-2){off[OFF_W-1]}}, off, 2'b00};
    return base + disp;
  endfunction

  logic unused_mid;
  assign unused_mid = ^instr[25:16];

  assign is_branch = (instr[31:26] == BR_OPC);
  assign br_target = rel_target(pc, instr[OFF_W-1:0]);
  assign seq_pc    = pc + ADDR_W'(4);
endmodule

// File: rtl/bht_table.sv
module bht_table
  import bht_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [1:0]       rd_ctr,
  input  logic             upd_valid,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic             upd_taken
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam int FLAT_W  = 2 * ENTRIES;

  logic [FLAT_W-1:0] ctr_flat;
  logic [1:0]        upd_old;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
    logic [1:0] q;
    logic       hit;
    assign hit = upd_valid && (upd_idx == IDX_W'(e));
    always_ff @(posedge clk) begin
      if (!rst_n)   q <= CTR_WNT;
      else if (hit) q <= ctr_step(q, upd_taken);
    end
    assign ctr_flat[2*e +: 2] = q;
  end

  assign rd_ctr  = ctr_flat[2*rd_idx +: 2];
  assign upd_old = ctr_flat[2*upd_idx +: 2];

  // checker state: last training event
  logic             chk_v, chk_tk;
  logic [IDX_W-1:0] chk_idx;
  logic [1:0]       chk_old;
  logic [1:0]       chk_now;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chk_v <= 1'b0; chk_tk <= 1'b0; chk_idx <= '0; chk_old <= '0;
    end else begin
      chk_v <= upd_valid; chk_tk <= upd_taken; chk_idx <= upd_idx; chk_old <= upd_old;
    end
  end
  assign chk_now = ctr_flat[2*chk_idx +: 2];

  // R2
  taken_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_v && chk_tk) |-> ({1'b0, chk_now} >= {1'b0, chk_old} &&
                           {1'b0, chk_now} <= {1'b0, chk_old} + 3'd1 &&
                           (chk_now != chk_old || chk_old == CTR_ST)));
  // R3
  fall_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_v && !chk_tk) |-> ({1'b0, chk_now} <= {1'b0, chk_old} &&
                            {1'b0, chk_now} + 3'd1 >= {1'b0, chk_old} &&
                            (chk_now != chk_old || chk_old == CTR_SNT)));
  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> $stable(ctr_flat));
endmodule

// File: rtl/bht_select.sv
module bht_select
  import bht_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              is_branch,
  input  logic [1:0]        ctr,
  input  logic [ADDR_W-1:0] br_target,
  input  logic [ADDR_W-1:0] seq_pc,
  output logic              take,
  output logic [ADDR_W-1:0] next_pc
);
  assign take    = is_branch && ctr_dir(ctr);
  assign next_pc = take ? br_target : seq_pc;
endmodule

// File: rtl/bht_predictor.sv
module bht_predictor
  import bht_pkg::*;
#(
  parameter int         ADDR_W = 32,
  parameter int         IDX_W  = 6,
  parameter logic [5:0] BR_OPC = 6'b000100
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  fetch_pc,
  input  logic [INSTR_W-1:0] fetch_instr,
  output logic [ADDR_W-1:0]  next_pc,
  output logic               pred_taken,
  input  logic               upd_valid,
  input  logic [ADDR_W-1:0]  upd_pc,
  input  logic               upd_taken
);
  localparam int IDX_LO = 2;
  localparam int IDX_HI = IDX_W + IDX_LO - 1;

  logic [IDX_W-1:0]  fetch_idx, train_idx;
  logic [1:0]        slot_ctr;
  logic              is_branch;
  logic [ADDR_W-1:0] br_target, seq_pc;
  logic              unused_upd;

  assign fetch_idx  = fetch_pc[IDX_HI:IDX_LO];
  assign train_idx  = upd_pc[IDX_HI:IDX_LO];
  assign unused_upd = ^{upd_pc[ADDR_W-1:IDX_HI+1], upd_pc[IDX_LO-1:0]};

  bht_decode #(.ADDR_W(ADDR_W), .BR_OPC(BR_OPC)) u_dec (
    .pc(fetch_pc), .instr(fetch_instr),
    .is_branch(is_branch), .br_target(br_target), .seq_pc(seq_pc)
  );

  bht_table #(.IDX_W(IDX_W)) u_tbl (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(fetch_idx), .rd_ctr(slot_ctr),
    .upd_valid(upd_valid), .upd_idx(train_idx), .upd_taken(upd_taken)
  );

  bht_select #(.ADDR_W(ADDR_W)) u_sel (
    .is_branch(is_branch), .ctr(slot_ctr),
    .br_target(br_target), .seq_pc(seq_pc),
    .take(pred_taken), .next_pc(next_pc)
  );

  // R8
  seq_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !is_branch |-> (next_pc == fetch_pc + ADDR_W'(4) && !pred_taken));
  // R4
  taken_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pred_taken |-> (next_pc == br_target && is_branch));
endmodule

// File: tb/sim_bht_predictor.sv
module sim_bht_predictor;
  localparam int AW = 32;
  localparam int KW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] fetch_pc = '0;
  logic [31:0]   fetch_instr = '0;
  logic [AW-1:0] next_pc;
  logic          pred_taken;
  logic          upd_valid = 1'b0;
  logic [AW-1:0] upd_pc = '0;
  logic          upd_taken = 1'b0;

  always #5 clk = ~clk;

  bht_predictor #(.ADDR_W(AW), .IDX_W(KW), .BR_OPC(6'b000100)) u0 (
    .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .fetch_instr(fetch_instr),
    .next_pc(next_pc), .pred_taken(pred_taken),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken)
  );

  typedef struct {
    logic [AW-1:0] nxt;
    logic          tk;
    string         req;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  int   model [8];

  function automatic logic [31:0] br(input logic [15:0] off);
    return {6'b000100, 10'd0, off};
  endfunction

  // driver: one cycle of stimulus, expected result pushed to scoreboard
  task automatic step(input logic [AW-1:0] pc, input logic [31:0] ins,
                      input logic uv, input logic [AW-1:0] upc, input logic ut,
                      input bit chk, input string req);
    exp_t e;
    int   ix, ux;
    logic isb;
    @(posedge clk); #1;
    fetch_pc = pc; fetch_instr = ins;
    upd_valid = uv; upd_pc = upc; upd_taken = ut;
    if (chk) begin
      ix  = int'((pc >> 2) & 32'h7);
      isb = (ins[31:26] == 6'd4);
      e.tk  = isb && (model[ix] >= 2);
      e.nxt = e.tk ? pc + 32'($signed(ins[15:0])) * 4 : pc + 32'd4;
      e.req = req;
      q.push_back(e);
    end
    if (uv) begin
      ux = int'((upc >> 2) & 32'h7);
      if (ut) model[ux] = (model[ux] == 3) ? 3 : model[ux] + 1;
      else    model[ux] = (model[ux] == 0) ? 0 : model[ux] - 1;
    end
  endtask

  task automatic probe(input logic [AW-1:0] pc, input logic [31:0] ins, input string req);
    step(pc, ins, 1'b0, '0, 1'b0, 1'b1, req);
  endtask

  task automatic train(input logic [AW-1:0] pc, input logic t);
    step(32'h0, 32'h0, 1'b1, pc, t, 1'b0, "");
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (next_pc !== e.nxt || pred_taken !== e.tk) begin
          errors++;
          $display("FAIL %s: next_pc=%h taken=%b expected next_pc=%h taken=%b",
                   e.req, next_pc, pred_taken, e.nxt, e.tk);
        end
      end
    end
  end

  initial begin
    #200000ns;
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    foreach (model[i]) model[i] = 1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset value: not taken, one step makes it taken
    probe(32'h100, br(16'h0008), "R1");
    train(32'h100, 1'b1);
    probe(32'h100, br(16'h0008), "R1 R4 weak taken");
    // R2 climb and saturate
    train(32'h100, 1'b1);
    train(32'h100, 1'b1);
    train(32'h100, 1'b1);
    train(32'h100, 1'b0);
    probe(32'h100, br(16'h0008), "R2 saturate high");
    // R3 descend and saturate
    train(32'h100, 1'b0);
    probe(32'h100, br(16'h0008), "R3 weak not-taken");
    train(32'h100, 1'b0);
    train(32'h100, 1'b0);
    train(32'h100, 1'b1);
    probe(32'h100, br(16'h0008), "R3 saturate low");
    train(32'h100, 1'b1);
    probe(32'h100, br(16'h0008), "R4 counter 10");
    // R5 aliasing: 0x120 shares slot 0 with 0x100
    train(32'h120, 1'b0);
    train(32'h120, 1'b0);
    probe(32'h100, br(16'h0008), "R5 alias shares counter");
    train(32'h120, 1'b1);
    train(32'h120, 1'b1);
    train(32'h120, 1'b1);
    probe(32'h104, br(16'h0010), "R5 other slot untouched");
    probe(32'h120, br(16'h0010), "R5 alias taken");
    // R8 non-branch at a taken slot
    probe(32'h100, 32'h0000_0008, "R8 non-branch");
    // R6 opcode one bit away
    probe(32'h100, {6'b000101, 10'd0, 16'h0008}, "R6 near opcode");
    probe(32'h100, {6'b100100, 10'd0, 16'h0008}, "R6 high bit");
    // R7 negative offset
    probe(32'h200, br(16'hFFFC), "R7 negative offset");
    probe(32'h200, br(16'h7FFF), "R7 large positive offset");
    // R9 same-cycle read and training, slot 1 at 01
    step(32'h104, br(16'h0004), 1'b1, 32'h104, 1'b1, 1'b1, "R9 old value");
    probe(32'h104, br(16'h0004), "R9 after update");
    // R10 strobe low with data present
    step(32'h108, br(16'h0004), 1'b0, 32'h108, 1'b1, 1'b0, "");
    step(32'h108, br(16'h0004), 1'b0, 32'h108, 1'b1, 1'b0, "");
    probe(32'h108, br(16'h0004), "R10 no effect");
    repeat (3) @(posedge clk);
    #1;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: %0d items left, expected 0", q.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule